// File: doc/BRIEF.md
# Complementary PWM Generator with Dead Time

This block drives one high-side and one low-side gate output from a single time base. A counter ramps either up only (edge-aligned) or up and then down (center-aligned). The high-side request is asserted while the count is below the duty value. Three output arrangements are available: complementary, redundant and push-pull. In complementary mode an output never turns on until its partner has been off for a programmed number of clocks. This rule holds whatever caused the edge, including an on-the-fly duty write, an override release or a period change.

Period and duty values can be double-buffered or can take effect at once. Double-buffered values load only at the end of a full cycle. A two-bit override forces either output to a programmed level. It takes effect either at the next clock or at the cycle boundary. A compare unit pulses a trigger when the count reaches a programmed value. A postscaler passes the first match after it is programmed and then every (N+1)-th match.

Registers are written through a simple write strobe, address and data port. Address map: 0 period, 1 duty, 2 high-side on-delay, 3 low-side on-delay, 4 control, 5 override, 6 trigger compare, 7 trigger divider. The data width must be at least 5 bits.

Top module: `pwmdt_gen`

## Requirements
- R1: Edge-aligned mode (control bit 0 = 0): the count runs 0 to P-1 and wraps to 0, where P is the active period. The high request is true while count < D, where D is the active duty. Outputs are registered and follow the request one clock later.
- R2: Center-aligned mode (control bit 0 = 1): the count climbs 0 to P-1, holds P-1 for one more clock and descends to 0. It then holds 0 for one more clock, so a cycle is 2P clocks long with 2D clocks of high request.
- R3: With control bit 3 = 0, written period and duty values load only after the cycle's last clock. In edge mode that is the clock where the count reaches P-1. In center mode it is the final clock at 0 while descending, never the turnaround at the top.
- R4: With control bit 3 = 1, a written duty or period value becomes active one clock after the write.
- R5: In complementary mode (control bits 2:1 = 00 or 11), an output falls one clock after its request drops. The high output rises only after both outputs have been low for the value in register 2, and the low output after the value in register 3. This holds for edges caused by duty writes, period writes and override release, and both outputs are never high together.
- R6: Duty 0 holds the low output on and the high output off for every clock. Duty at or above P holds the high output on for every clock, even with non-zero dead time.
- R7: Output mode is control bits 2:1. 01 is redundant: both outputs equal the high request. 10 is push-pull: the request goes to the high output in one cycle and the low output in the next, starting with the high output. Dead time applies only in complementary mode.
- R8: In redundant or push-pull mode with buffered updates, a duty change from non-zero to 0 yields no high clock on either output in the following cycle.
- R9: Override register bits 1:0 enable forcing of {high, low} and bits 3:2 give their forced levels {high, low}. Data 01 gives high off / low on, and data 10 gives high on / low off.
- R10: Override register bit 4 = 1 applies override changes only after the cycle's last clock. Bit 4 = 0 applies them one clock after the write.
- R11: A match occurs when the count equals register 6, counted only while ascending in center mode. The trigger pulses one clock after a passed match. Writing register 7 (value N) restarts the postscaler, so the first following match passes and then every (N+1)-th match passes.
- R12: During reset the count, both outputs and the trigger are 0. One clock after release the low output is on, because duty resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| cnt_o | output | CW | Current time-base count |
| pwm_hi | output | 1 | High-side output |
| pwm_lo | output | 1 | Low-side output |
| trig | output | 1 | Compare trigger pulse |

## Verification
A wrong count or direction shows on `cnt_o` within one clock and changes the measured on-time of a cycle. A dead-time counter that is not cleared or released correctly shows up on the next edge: the low gap before a rise becomes shorter than the programmed value, or both outputs are high together. A badly timed shadow load appears as a duty or period change inside the current cycle, visible at a sampled count position before the boundary. A postscaler left in the wrong state drops or adds a trigger pulse within the first compare period after the divider is written.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;
  typedef enum logic [1:0] {
    OM_COMP     = 2'b00,
    OM_REDUND   = 2'b01,
    OM_PUSHPULL = 2'b10,
    OM_SPARE    = 2'b11
  } outmode_e;

  localparam logic [2:0] A_PERIOD = 3'd0;
  localparam logic [2:0] A_DUTY   = 3'd1;
  localparam logic [2:0] A_DTHI   = 3'd2;
  localparam logic [2:0] A_DTLO   = 3'd3;
  localparam logic [2:0] A_CTRL   = 3'd4;
  localparam logic [2:0] A_OVR    = 3'd5;
  localparam logic [2:0] A_TCMP   = 3'd6;
  localparam logic [2:0] A_TDIV   = 3'd7;
endpackage

// File: rtl/pwmdt_regs.sv
module pwmdt_regs
  import pwmdt_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DTW = 4,
  parameter int TPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic           boundary,
  output logic [CW-1:0]  per_a,
  output logic [CW-1:0]  duty_a,
  output logic [DTW-1:0] dt_hi,
  output logic [DTW-1:0] dt_lo,
  output logic           center,
  output outmode_e       mode,
  output logic [1:0]     oen_a,
  output logic [1:0]     odat_a,
  output logic [CW-1:0]  tcmp,
  output logic [TPW-1:0] tdiv,
  output logic           tdiv_wr
);
  logic [CW-1:0] per_w, duty_w;
  logic          imm_w, sync_w;
  logic [1:0]    oen_w, odat_w;
  logic          ld_pd, ld_ov;

  always_comb begin
    ld_pd   = imm_w | boundary;
    ld_ov   = ~sync_w | boundary;
    tdiv_wr = wr_en && (wr_addr == A_TDIV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_w  <= '0;
      duty_w <= '0;
      dt_hi  <= '0;
      dt_lo  <= '0;
      center <= 1'b0;
      mode   <= OM_COMP;
      imm_w  <= 1'b0;
      oen_w  <= '0;
      odat_w <= '0;
      sync_w <= 1'b0;
      tcmp   <= '0;
      tdiv   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PERIOD: per_w  <= wr_data;
        A_DUTY:   duty_w <= wr_data;
        A_DTHI:   dt_hi  <= wr_data[DTW-1:0];
        A_DTLO:   dt_lo  <= wr_data[DTW-1:0];
        A_CTRL: begin
          center <= wr_data[0];
          mode   <= outmode_e'(wr_data[2:1]);
          imm_w  <= wr_data[3];
        end
        A_OVR: begin
          oen_w  <= wr_data[1:0];
          odat_w <= wr_data[3:2];
          sync_w <= wr_data[4];
        end
        A_TCMP:   tcmp <= wr_data;
        default:  tdiv <= wr_data[TPW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a  <= '0;
      duty_a <= '0;
      oen_a  <= '0;
      odat_a <= '0;
    end else begin
      if (ld_pd) begin
        per_a  <= per_w;
        duty_a <= duty_w;
      end
      if (ld_ov) begin
        oen_a  <= oen_w;
        odat_a <= odat_w;
      end
    end
  end

  AST_BUF_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_w && !boundary) |=> $stable(duty_a)); // R3
  AST_OVR_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_w && !boundary) |=> $stable(oen_a)); // R10
endmodule

// File: rtl/pwmdt_timebase.sv
module pwmdt_timebase #(
  parameter int CW  = 8,
  parameter int TPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           center,
  input  logic [CW-1:0]  per_a,
  input  logic [CW-1:0]  tcmp,
  input  logic [TPW-1:0] tdiv,
  input  logic           tdiv_wr,
  output logic [CW-1:0]  cnt,
  output logic           boundary,
  output logic           pp,
  output logic           trig
);
  logic           up, up_n;
  logic [CW-1:0]  cnt_n, top;
  logic           at_top, match, fire;
  logic [TPW-1:0] pc, pc_n;

  always_comb begin
    top    = per_a - 1'b1;
    at_top = (cnt >= top);
    cnt_n  = cnt;
    up_n   = up;
    if (!center) begin
      up_n  = 1'b1;
      cnt_n = at_top ? '0 : cnt + 1'b1;
    end else if (up) begin
      if (at_top) up_n = 1'b0;
      else        cnt_n = cnt + 1'b1;
    end else begin
      if (cnt == '0) up_n = 1'b1;
      else           cnt_n = cnt - 1'b1;
    end
    boundary = center ? (!up && (cnt == '0)) : at_top;
    match    = (cnt == tcmp) && (!center || up);
    fire     = match && (pc == '0);
    pc_n     = pc;
    if (tdiv_wr)    pc_n = '0;
    else if (match) pc_n = (pc >= tdiv) ? '0 : pc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      up   <= 1'b1;
      pp   <= 1'b0;
      pc   <= '0;
      trig <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      up   <= up_n;
      pc   <= pc_n;
      trig <= fire;
      if (boundary) pp <= ~pp;
    end
  end

  AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!center && boundary) |=> (cnt == '0)); // R1
  AST_CENTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (center && boundary) |=> (cnt == '0)); // R2
  AST_TRIG_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(match)); // R11
endmodule

// File: rtl/pwmdt_deadband.sv
module pwmdt_deadband #(
  parameter int DTW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tgt,
  input  logic [DTW-1:0] dt,
  output logic           out
);
  logic [DTW-1:0] dc, dc_n;
  logic           out_n;

  always_comb begin
    out_n = out;
    dc_n  = dc;
    if (!tgt) begin
      out_n = 1'b0;
      dc_n  = '0;
    end else if (!out) begin
      if (dc >= dt) out_n = 1'b1;
      else          dc_n  = dc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out <= 1'b0;
      dc  <= '0;
    end else begin
      out <= out_n;
      dc  <= dc_n;
    end
  end

  AST_FALL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt |=> !out); // R5
  AST_RISE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out) |-> $past(tgt)); // R5
endmodule

// File: rtl/pwmdt_gen.sv
module pwmdt_gen
  import pwmdt_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DTW = 4,
  parameter int TPW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt_o,
  output logic          pwm_hi,
  output logic          pwm_lo,
  output logic          trig
);
  localparam int NOUT = 2;

  logic [CW-1:0]  per_a, duty_a, tcmp;
  logic [DTW-1:0] dt_hi, dt_lo;
  logic [TPW-1:0] tdiv;
  logic           center, tdiv_wr, boundary, pp, raw, comp, ovr_any;
  logic [1:0]     oen_a, odat_a, want, tgt, outs;
  logic [DTW-1:0] dt_sel [NOUT];
  outmode_e       mode;

  pwmdt_regs #(.CW(CW), .DTW(DTW), .TPW(TPW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .boundary(boundary), .per_a(per_a), .duty_a(duty_a),
    .dt_hi(dt_hi), .dt_lo(dt_lo), .center(center), .mode(mode),
    .oen_a(oen_a), .odat_a(odat_a), .tcmp(tcmp), .tdiv(tdiv),
    .tdiv_wr(tdiv_wr)
  );

  pwmdt_timebase #(.CW(CW), .TPW(TPW)) u_tb (
    .clk(clk), .rst_n(rst_n), .center(center), .per_a(per_a), .tcmp(tcmp),
    .tdiv(tdiv), .tdiv_wr(tdiv_wr), .cnt(cnt_o), .boundary(boundary),
    .pp(pp), .trig(trig)
  );

  always_comb begin
    raw  = (cnt_o < duty_a);
    comp = (mode == OM_COMP) || (mode == OM_SPARE);
    case (mode)
      OM_REDUND:   want = {raw, raw};
      OM_PUSHPULL: want = {raw & ~pp, raw & pp};
      default:     want = {raw, ~raw};
    endcase
    for (int i = 0; i < NOUT; i++)
      tgt[i] = oen_a[i] ? odat_a[i] : want[i];
    dt_sel[1] = comp ? dt_hi : '0;
    dt_sel[0] = comp ? dt_lo : '0;
    ovr_any   = |oen_a;
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_db
    pwmdt_deadband #(.DTW(DTW)) u_db (
      .clk(clk), .rst_n(rst_n), .tgt(tgt[g]), .dt(dt_sel[g]), .out(outs[g])
    );
  end

  assign pwm_hi = outs[1];
  assign pwm_lo = outs[0];

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (comp && $past(comp) && !ovr_any && !$past(ovr_any))
      |-> !(pwm_hi && pwm_lo)); // R5
endmodule

// File: tb/sim_pwmdt_gen.sv
module sim_pwmdt_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] cnt;
  logic       pwm_hi, pwm_lo, trig;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit mon_on = 0;
  int mon_dth = 0, mon_dtl = 0, lowrun = 0, mon_hits = 0;
  logic ph = 0, pl = 0;

  pwmdt_gen #(.CW(8), .DTW(4), .TPW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .trig(trig)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R5 monitor: low gap before each rise, and no overlap
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (pwm_hi && !ph) begin
        mon_hits++;
        chk("R5 high rise gap ok", int'(lowrun >= mon_dth), 1);
      end
      if (pwm_lo && !pl) begin
        mon_hits++;
        chk("R5 low rise gap ok", int'(lowrun >= mon_dtl), 1);
      end
      if (pwm_hi && pwm_lo) chk("R5 overlap", 1, 0);
    end
    lowrun = (!pwm_hi && !pwm_lo) ? lowrun + 1 : 0;
    ph = pwm_hi;
    pl = pwm_lo;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(int v);
    @(negedge clk);
    while (int'(cnt) != v) @(negedge clk);
  endtask

  task automatic meas(int n, output int h, output int l, output int b, output int d);
    h = 0; l = 0; b = 0; d = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h += int'(pwm_hi); l += int'(pwm_lo);
      b += int'(pwm_hi && pwm_lo); d += int'(pwm_hi != pwm_lo);
    end
  endtask

  task automatic max_cnt(int n, output int m);
    m = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (int'(cnt) > m) m = int'(cnt);
    end
  endtask

  task automatic meas_trig(int n, output int t, output int at);
    t = 0; at = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trig) begin t++; at = int'(cnt); end
    end
  endtask

  // ctrl: bit0 center, bits2:1 mode, bit3 immediate
  task automatic cfg(int ctrl, int per, int duty, int dth, int dtl);
    mon_on = 0;
    wr(4, 8 | (ctrl & 7));
    wr(0, per); wr(1, duty); wr(2, dth); wr(3, dtl); wr(5, 0);
    wr(4, ctrl);
    tick(2 * per + 6);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tick(3);
    rst_n = 1'b1;
    chk("R12 cnt", int'(cnt), 0);
    chk("R12 hi", int'(pwm_hi), 0);
    chk("R12 lo", int'(pwm_lo), 0);
    chk("R12 trig", int'(trig), 0);
    tick(1);
    chk("R12 lo on after release", int'(pwm_lo), 1);
  endtask

  task automatic t_edge;
    int h, l, b, d, m;
    cfg(8, 10, 4, 0, 0);
    mon_dth = 0; mon_dtl = 0; mon_on = 1;
    meas(10, h, l, b, d);
    chk("R1 hi count D4", h, 4);
    chk("R1 lo count D4", l, 6);
    chk("R7 comp no overlap", b, 0);
    max_cnt(20, m);
    chk("R1 max count", m, 9);
    wr(1, 7); tick(12);
    meas(10, h, l, b, d);
    chk("R1 hi count D7", h, 7);
    chk("R1 lo count D7", l, 3);
  endtask

  task automatic t_deadtime;
    int h, l, b, d;
    cfg(8, 10, 4, 2, 3);
    mon_dth = 2; mon_dtl = 3; mon_on = 1;
    meas(10, h, l, b, d);
    chk("R5 hi shortened by 2", h, 2);
    chk("R5 lo shortened by 3", l, 3);
    meas(20, h, l, b, d);
    chk("R5 never both high", b, 0);
  endtask

  task automatic t_center;
    int h, l, b, d, m;
    cfg(9, 6, 2, 0, 0);
    mon_dth = 0; mon_dtl = 0; mon_on = 1;
    meas(12, h, l, b, d);
    chk("R2 hi count", h, 4);
    chk("R2 lo count", l, 8);
    max_cnt(12, m);
    chk("R2 peak count", m, 5);
  endtask

  task automatic t_extremes;
    int h, l, b, d;
    cfg(8, 10, 0, 3, 3);
    meas(20, h, l, b, d);
    chk("R6 duty0 hi", h, 0);
    chk("R6 duty0 lo", l, 20);
    wr(1, 10); tick(8);
    meas(20, h, l, b, d);
    chk("R6 full hi", h, 20);
    chk("R6 full lo", l, 0);
    cfg(9, 6, 6, 3, 3);
    meas(24, h, l, b, d);
    chk("R6 center full hi", h, 24);
  endtask

  task automatic t_buffered;
    cfg(0, 10, 4, 0, 0);
    wait_cnt(2); wr(1, 7);
    wait_cnt(6);
    chk("R3 duty held in cycle", int'(pwm_hi), 0);
    wait_cnt(6);
    chk("R3 duty loaded next cycle", int'(pwm_hi), 1);
  endtask

  task automatic t_immediate;
    int base;
    cfg(8, 10, 4, 0, 0);
    wait_cnt(2); wr(1, 7);
    wait_cnt(6);
    chk("R4 duty applied at once", int'(pwm_hi), 1);
    cfg(8, 20, 4, 3, 3);
    mon_dth = 3; mon_dtl = 3; mon_on = 1;
    base = mon_hits;
    wait_cnt(8); wr(1, 15);
    tick(10);
    chk("R5 immediate edge gap checked", int'(mon_hits > base), 1);
  endtask

  task automatic t_modes;
    int h, l, b, d;
    cfg(10, 10, 4, 0, 0);
    meas(10, h, l, b, d);
    chk("R7 redundant hi", h, 4);
    chk("R7 redundant lo", l, 4);
    chk("R7 redundant equal", d, 0);
    wr(4, 2);
    wait_cnt(5); wr(1, 0);
    wait_cnt(0);
    meas(10, h, l, b, d);
    chk("R8 redundant zero hi", h, 0);
    chk("R8 redundant zero lo", l, 0);
    cfg(4, 10, 4, 0, 0);
    meas(20, h, l, b, d);
    chk("R7 pushpull hi", h, 4);
    chk("R7 pushpull lo", l, 4);
    chk("R7 pushpull no overlap", b, 0);
    wait_cnt(5); wr(1, 0);
    wait_cnt(0);
    meas(20, h, l, b, d);
    chk("R8 pushpull zero", h + l, 0);
  endtask

  task automatic t_override;
    int h, l, b, d, base;
    cfg(8, 10, 4, 0, 0);
    mon_dth = 0; mon_dtl = 0; mon_on = 1;
    wr(5, 7); tick(3);
    meas(20, h, l, b, d);
    chk("R9 data01 hi", h, 0);
    chk("R9 data01 lo", l, 20);
    wr(5, 11); tick(3);
    meas(20, h, l, b, d);
    chk("R9 data10 hi", h, 20);
    chk("R9 data10 lo", l, 0);
    wr(5, 0); tick(12);
    wait_cnt(3); wr(5, 27);
    wait_cnt(9);
    chk("R10 sync waits for boundary", int'(pwm_hi), 0);
    wait_cnt(6);
    chk("R10 sync applied hi", int'(pwm_hi), 1);
    chk("R10 sync applied lo", int'(pwm_lo), 0);
    cfg(8, 10, 8, 3, 3);
    mon_dth = 3; mon_dtl = 3; mon_on = 1;
    wr(5, 7); tick(12);
    base = mon_hits;
    wait_cnt(0); wr(5, 0);
    tick(10);
    chk("R5 release edge gap checked", int'(mon_hits > base), 1);
  endtask

  task automatic t_center_period;
    int m;
    cfg(1, 6, 2, 0, 0);
    wait_cnt(5); @(negedge clk);
    wait_cnt(0);
    tick(2);
    wr(0, 8);
    max_cnt(8, m);
    chk("R3 no load at turnaround", m, 5);
    max_cnt(20, m);
    chk("R3 center period loaded", m, 7);
  endtask

  task automatic t_period_change;
    int base;
    cfg(8, 10, 4, 2, 2);
    mon_dth = 2; mon_dtl = 2; mon_on = 1;
    base = mon_hits;
    wait_cnt(7); wr(0, 3);
    tick(12);
    wr(0, 10);
    tick(25);
    chk("R5 period change edges checked", int'(mon_hits > base), 1);
  endtask

  task automatic t_trigger;
    int t, at;
    cfg(8, 10, 4, 0, 0);
    wr(6, 2);
    wait_cnt(5); wr(7, 2);
    meas_trig(10, t, at);
    chk("R11 first match fires", t, 1);
    chk("R11 pulse position", at, 3);
    meas_trig(60, t, at);
    chk("R11 postscaled pulses", t, 2);
    wr(6, 0);
    wait_cnt(5); wr(7, 5);
    meas_trig(10, t, at);
    chk("R11 compare 0 first match", t, 1);
    cfg(9, 6, 2, 0, 0);
    wr(6, 3); wr(7, 0);
    meas_trig(24, t, at);
    chk("R11 center up-count only", t, 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      chk("watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    @(negedge clk);
    t_reset();
    t_edge();
    t_deadtime();
    t_center();
    t_extremes();
    t_buffered();
    t_immediate();
    t_modes();
    t_override();
    t_center_period();
    t_period_change();
    t_trigger();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule